// File: doc/BRIEF.md
# Four-Lane Signal Duty Counter Set

This block is one set of hardware activity monitors. It watches a wide bundle of internal probe signals. Four lanes each pick one probe through their own selector. A lane counts the clock cycles in which a small per-lane truth table, fed by the picked probes, evaluates to 1. A shared cycle counter runs alongside the lanes and measures the length of the window. Software takes each lane count, divides it by the cycle count and gets a duty cycle. A chip that needs more sets places more copies of the block.

Software first raises the arm input, then programs the selectors and the truth tables, then raises the run input. The rising edge of run clears every counter and starts a window. Dropping run closes the window. After that all five counts stay frozen, so software can read them one after another and get a coherent set. The counts are plain status outputs. No data streams through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `perfmon_set`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, the cycle count and all four lane counts are zero.
- R2: A clock edge at which arm_i and run_i are both 1, after a cycle with run_i at 0, restarts the window. The cycle count becomes 1. Each lane count becomes 1 if that lane hits in that cycle, and 0 if it does not. This restart takes priority over saturation.
- R3: At every later edge with arm_i and run_i both 1, the cycle count increases by one.
- R4: With truth table 16'hAAAA, a lane increases by one at each counting edge where probe_i[sel_i[lane]] is 1. The lane's probe is taken from sel_i[lane], which is a binary index into probe_i.
- R5: Lane k builds a 4-bit index. Bit j of that index is the probe picked by lane (k+j) mod 4. The lane counts a hit when bit <index> of mode_i[k] is 1. So 16'hCCCC follows the next lane's probe, 16'hFFFF counts every cycle and 16'h0000 never counts.
- R6: No counter wraps. Once a counter reaches its all-ones value, it stays there until the next restart.
- R7: While run_i is 0, every count holds its value, even when probe_i, sel_i or mode_i change.
- R8: While arm_i is 0, a rising run_i neither clears nor advances any count. If arm_i is then raised while run_i is still 1, counting resumes from the held values with no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Set enable; counting happens only while it is 1 |
| run_i | input | 1 | Window control; its rising edge clears, its low level freezes |
| probe_i | input | NSIG | Candidate probe signals |
| sel_i | input | 4 x log2(NSIG) | Probe index for each lane |
| mode_i | input | 4 x 16 | Truth table for each lane (16'hAAAA counts the lane's own probe level) |
| evt_cnt_o | output | 4 x CW | Lane counts |
| cyc_cnt_o | output | CW | Window length in cycles |

## Verification
Two events can fall in the same cycle: a restart and a counter that is already saturated. The bench drives every counter to its all-ones limit with a long window on a narrow counter configuration. It then drops run for a single cycle and raises it again. The check passes only if the counts reload from 1 or 0 in the rising cycle itself, instead of staying pinned at the limit. A second overlap comes from raising arm while run is already high. The bench provokes it and checks that the counts resume from their held values and are not cleared.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int unsigned LANES = 4;

  // lane whose probe feeds bit j of lane k's truth-table index
  function automatic int unsigned tap_lane(input int unsigned k, input int unsigned j);
    return (k + j) % LANES;
  endfunction
endpackage

// File: rtl/perfmon_probe_pick.sv
module perfmon_probe_pick #(
  parameter int NSIG = 256,
  parameter int SELW = 8
) (
  input  logic [NSIG-1:0] probe,
  input  logic [SELW-1:0] sel,
  output logic            bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < NSIG; i++)
      if (sel == SELW'(i)) bit_o = probe[i];
  end
endmodule

// File: rtl/perfmon_lut.sv
module perfmon_lut #(
  parameter int NIN = 4,
  localparam int TW = 1 << NIN
) (
  input  logic [NIN-1:0] taps,
  input  logic [TW-1:0]  table_i,
  output logic           hit
);
  assign hit = table_i[taps];
endmodule

// File: rtl/perfmon_satcnt.sv
module perfmon_satcnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          en,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= CW'(inc);
    else if (en && inc && cnt != TOP)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/perfmon_set.sv
module perfmon_set #(
  parameter int NSIG = 256,
  parameter int CW   = 32,
  localparam int NLANE = perfmon_pkg::LANES,
  localparam int SELW  = $clog2(NSIG),
  localparam int MODEW = 1 << NLANE
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm_i,
  input  logic                        run_i,
  input  logic [NSIG-1:0]             probe_i,
  input  logic [NLANE-1:0][SELW-1:0]  sel_i,
  input  logic [NLANE-1:0][MODEW-1:0] mode_i,
  output logic [NLANE-1:0][CW-1:0]    evt_cnt_o,
  output logic [CW-1:0]               cyc_cnt_o
);
  logic             run_q;
  logic             counting;
  logic             restart;
  logic [NLANE-1:0] picked;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_i;
  end

  assign counting = arm_i & run_i;
  assign restart  = counting & ~run_q;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [NLANE-1:0] taps;
    logic             hit;

    perfmon_probe_pick #(.NSIG(NSIG), .SELW(SELW)) u_pick (
      .probe(probe_i), .sel(sel_i[k]), .bit_o(picked[k])
    );

    for (genvar j = 0; j < NLANE; j++) begin : g_tap
      assign taps[j] = picked[perfmon_pkg::tap_lane(k, j)];
    end

    perfmon_lut #(.NIN(NLANE)) u_lut (
      .taps(taps), .table_i(mode_i[k]), .hit(hit)
    );

    perfmon_satcnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .en(counting),
      .inc(hit), .cnt(evt_cnt_o[k])
    );
  end

  perfmon_satcnt #(.CW(CW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .en(counting),
    .inc(1'b1), .cnt(cyc_cnt_o)
  );
endmodule

// File: rtl/perfmon_set_chk.sv
module perfmon_set_chk #(
  parameter int NLANE = 4,
  parameter int CW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     arm_i,
  input logic                     run_i,
  input logic [NLANE-1:0][CW-1:0] evt_cnt_o,
  input logic [CW-1:0]            cyc_cnt_o
);
  localparam logic [CW-1:0] TOP = '1;
  logic was_run;

  always_ff @(posedge clk) begin
    if (!rst_n) was_run <= 1'b0;
    else        was_run <= run_i;
  end

  // R2 restart reloads the cycle count with 1
  a_r2_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && run_i && !was_run) |=> (cyc_cnt_o == CW'(1)));

  // R3 steady step
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && run_i && was_run && cyc_cnt_o != TOP) |=> (cyc_cnt_o == $past(cyc_cnt_o) + 1'b1));

  // R6 saturation
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && run_i && was_run && cyc_cnt_o == TOP) |=> (cyc_cnt_o == TOP));

  // R7 and R8 freeze
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_i && run_i) |=> ($stable(cyc_cnt_o) && $stable(evt_cnt_o)));

  // R4 a lane never counts more cycles than the window holds
  for (genvar k = 0; k < NLANE; k++) begin : g_le
    a_r4_lane_le_window: assert property (@(posedge clk) disable iff (!rst_n)
      evt_cnt_o[k] <= cyc_cnt_o);
  end
endmodule

bind perfmon_set perfmon_set_chk #(.NLANE(NLANE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .run_i(run_i),
  .evt_cnt_o(evt_cnt_o), .cyc_cnt_o(cyc_cnt_o)
);

// File: tb/sim_perfmon_set.sv
module sim_perfmon_set;
  localparam int NSIG = 16;
  localparam int CW   = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic run = 1'b0;
  logic [NSIG-1:0] probe = '0;
  logic [3:0][3:0] sel = '0;
  logic [3:0][15:0] mode = '0;
  logic [3:0][CW-1:0] evt;
  logic [CW-1:0] cyc;

  int checks = 0;
  int errors = 0;
  int exp_e[4];
  int exp_c = 0;
  bit run_p = 1'b0;
  logic [15:0] lf = 16'h1ACE;

  always #5 clk = ~clk;

  perfmon_set #(.NSIG(NSIG), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .run_i(run), .probe_i(probe),
    .sel_i(sel), .mode_i(mode), .evt_cnt_o(evt), .cyc_cnt_o(cyc)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit lane_hit(input int k);
    logic [3:0] idx;
    for (int j = 0; j < 4; j++) idx[j] = probe[sel[(k + j) % 4]];
    return mode[k][idx];
  endfunction

  // one clock: inputs already set, model follows the requirements
  task automatic tick();
    bit h[4];
    @(posedge clk);
    for (int k = 0; k < 4; k++) h[k] = lane_hit(k);
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) exp_e[k] = 0;
      exp_c = 0;
      run_p = 1'b0;
    end else begin
      if (arm && run) begin
        if (!run_p) begin
          exp_c = 1;
          for (int k = 0; k < 4; k++) exp_e[k] = h[k] ? 1 : 0;
        end else begin
          if (exp_c < MAXV) exp_c++;
          for (int k = 0; k < 4; k++) if (h[k] && exp_e[k] < MAXV) exp_e[k]++;
        end
      end
      run_p = run;
    end
    @(negedge clk);
  endtask

  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    probe = lf;
    tick();
  endtask

  task automatic check_all(input string req);
    check({req, " cycles"}, int'(cyc), exp_c);
    for (int k = 0; k < 4; k++) check({req, " lane"}, int'(evt[k]), exp_e[k]);
  endtask

  task automatic window(input int n);
    run = 1'b1;
    for (int i = 0; i < n; i++) step_lfsr();
    run = 1'b0;
    step_lfsr();
  endtask

  initial begin
    for (int k = 0; k < 4; k++) exp_e[k] = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();
    check_all("R1 in reset");
    rst_n = 1'b1;
    tick();
    check_all("R1 after release");
    arm = 1'b1;

    // R4 selector sweep with level counting
    for (int s = 0; s < NSIG; s++) begin
      for (int k = 0; k < 4; k++) begin
        sel[k] = 4'((s + 5 * k) % NSIG);
        mode[k] = 16'hAAAA;
      end
      window(12);
      check_all("R4 sweep");
      check("R3 window", int'(cyc), 12);
    end

    // R5 truth-table sweep
    for (int m = 0; m < 8; m++) begin
      logic [15:0] tv;
      case (m)
        0: tv = 16'hCCCC; 1: tv = 16'hF0F0; 2: tv = 16'hFF00; 3: tv = 16'h8888;
        4: tv = 16'hFFFF; 5: tv = 16'h0000; 6: tv = 16'h6666; default: tv = 16'hFEFE;
      endcase
      for (int k = 0; k < 4; k++) begin
        mode[k] = tv;
        sel[k] = 4'((m + 3 * k) % NSIG);
      end
      window(15);
      check_all("R5 mode");
    end
    check("R5 never", int'(evt[0]), 3'd0 + exp_e[0]);

    // R6 saturation
    for (int k = 0; k < 4; k++) mode[k] = 16'hAAAA;
    mode[3] = 16'h0000;
    run = 1'b1;
    probe = '1;
    for (int i = 0; i < 70; i++) tick();
    check("R6 cycles", int'(cyc), MAXV);
    check("R6 lane", int'(evt[0]), MAXV);
    check("R6 silent lane", int'(evt[3]), 0);
    check_all("R6 all");

    // R2 restart on a saturated set
    run = 1'b0;
    tick();
    run = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    check("R2 restart cycles", int'(cyc), 3);
    check("R2 restart lane", int'(evt[1]), 3);

    // R7 freeze under changing inputs
    run = 1'b0;
    tick();
    for (int i = 0; i < 10; i++) begin
      sel[i % 4] = 4'(i);
      mode[(i + 1) % 4] = 16'hFFFF;
      step_lfsr();
    end
    check("R7 hold cycles", int'(cyc), 3);
    check_all("R7 hold");

    // R8 unarmed start, then late arm
    arm = 1'b0;
    run = 1'b1;
    for (int i = 0; i < 5; i++) step_lfsr();
    check("R8 unarmed cycles", int'(cyc), 3);
    check_all("R8 unarmed");
    arm = 1'b1;
    for (int i = 0; i < 4; i++) step_lfsr();
    check("R8 resume cycles", int'(cyc), 7);
    check_all("R8 resume");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule